// File: doc/BRIEF.md
# Banked Configurable Interrupt Controller

This block gathers interrupt requests from a set of external sources into banks of 32 and drives one interrupt line per bank toward a processor. Each source has its own trigger type, selected by two configuration bits: a polarity bit and an edge bit. A source can respond to a high level, a low level, a rising edge or a falling edge. Edge events are held in a pending bit until software acknowledges them. A level source's pending bit follows the input.

Software reaches each bank through six word registers on a simple single-cycle register bus. Writes land on the next rising clock edge and reads return data combinationally from the address. The registers hold the pending status, the enable mask, a software set strobe, a write-one-to-clear acknowledge strobe, the polarity bits and the edge-select bits. A bank's interrupt line is high whenever any source in that bank is both pending and enabled. Global source number g is wired to `src_i[g]`: it belongs to bank g>>5, at bit position g&31.

Top module: `intc_banked`

## Requirements
- R1: Bank b starts at byte address b*0x18. Within a bank the word offsets are 0x00 status, 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 edge select. Status, enable, polarity and edge select read back their current values. Set, clear and any unmapped address read as zero. A write to enable, polarity or edge select takes effect on the next rising edge.
- R2: The trigger type of each source comes from its polarity bit p and its edge bit e:
  - p=1, e=0: active-high level.
  - p=0, e=0: active-low level.
  - p=1, e=1: rising edge.
  - p=0, e=1: falling edge.
- R3: In edge mode an event sets the status bit, and the bit stays set until a clear write carries a 1 in that bit position. Clear bits written as 0 leave status unchanged.
- R4: In level mode the status bit equals the polarity-corrected synchronized input on every cycle. A clear write has no lasting effect while the level is still active.
- R5: Writing 1 to a bit of the set register forces that status bit to 1. In edge mode the bit then stays set until it is cleared. In level mode it is set for one cycle and then follows the input again. Set bits written as 0 have no effect.
- R6: `irq_o[b]` is 1 exactly when bank b has a bit whose status and enable are both 1.
- R7: Each input passes through a two-flop synchronizer. An input change driven between clock edges reaches the status register on the third rising edge after it.
- R8: While reset is asserted, every status, enable, polarity and edge-select bit is zero and every `irq_o` bit is zero.
- R9: Input `src_i[g]` drives bank g>>5, status bit g&31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Interrupt source inputs; index is the global source number |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| irq_o | output | NUM_BANKS | One interrupt line per bank |

## Verification
The bench builds the block with NUM_BANKS = 3 and ADDR_W = 8. With three banks the bases 0x18 and 0x30 are both in use, so address decode is exercised away from bank 0, and there is an unmapped address above the last bank. Source 40 lands in the middle bank, which tests the global-number mapping together with per-bank isolation of `irq_o`. All four trigger encodings are run on one source, each with an input sequence that should latch and one that should not.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_W       = 32;
  localparam int BANK_STRIDE = 24;
  localparam int OFS_W       = 5;

  localparam logic [OFS_W-1:0] OFS_STATUS = 5'h00;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 5'h04;
  localparam logic [OFS_W-1:0] OFS_SET    = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_POL    = 5'h10;
  localparam logic [OFS_W-1:0] OFS_EDGE   = 5'h14;

  typedef struct packed {
    logic enable;
    logic set;
    logic clear;
    logic pol;
    logic edge_sel;
  } bank_wr_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  bank_wr_t         wr_i,
  input  logic [SRC_W-1:0] wdata_i,
  input  logic [OFS_W-1:0] rd_off_i,
  output logic [SRC_W-1:0] rd_data_o,
  output logic [SRC_W-1:0] status_o,
  output logic [SRC_W-1:0] enable_o,
  output logic [SRC_W-1:0] edge_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] sync_w;
  logic [SRC_W-1:0] prev_q;
  logic [SRC_W-1:0] status_q, status_d;
  logic [SRC_W-1:0] enable_q, enable_d;
  logic [SRC_W-1:0] pol_q,    pol_d;
  logic [SRC_W-1:0] edge_q,   edge_d;
  logic [SRC_W-1:0] level_act;
  logic [SRC_W-1:0] edge_evt;
  logic [SRC_W-1:0] set_bits;
  logic [SRC_W-1:0] clr_bits;

  intc_sync #(.WIDTH(SRC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (sync_w)
  );

  always_comb begin
    set_bits  = wr_i.set   ? wdata_i : '0;
    clr_bits  = wr_i.clear ? wdata_i : '0;
    level_act = ~(sync_w ^ pol_q);
    edge_evt  = (pol_q & sync_w & ~prev_q) | (~pol_q & ~sync_w & prev_q);
    for (int i = 0; i < SRC_W; i++) begin
      if (edge_q[i]) begin
        status_d[i] = (status_q[i] & ~clr_bits[i]) | edge_evt[i] | set_bits[i];
      end else begin
        status_d[i] = level_act[i] | set_bits[i];
      end
    end
    enable_d = wr_i.enable   ? wdata_i : enable_q;
    pol_d    = wr_i.pol      ? wdata_i : pol_q;
    edge_d   = wr_i.edge_sel ? wdata_i : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      enable_q <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
    end else begin
      prev_q   <= sync_w;
      status_q <= status_d;
      enable_q <= enable_d;
      pol_q    <= pol_d;
      edge_q   <= edge_d;
    end
  end

  always_comb begin
    case (rd_off_i)
      OFS_STATUS: rd_data_o = status_q;
      OFS_ENABLE: rd_data_o = enable_q;
      OFS_POL:    rd_data_o = pol_q;
      OFS_EDGE:   rd_data_o = edge_q;
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o    = |(status_q & enable_q);
  assign status_o = status_q;
  assign enable_o = enable_q;
  assign edge_o   = edge_q;
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*SRC_W-1:0] src_i,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [SRC_W-1:0]           bus_wdata,
  output logic [SRC_W-1:0]           bus_rdata,
  output logic [NUM_BANKS-1:0]       irq_o
);
  localparam int MAP_BYTES = NUM_BANKS * BANK_STRIDE;

  initial begin
    if (MAP_BYTES > (1 << ADDR_W)) $error("address width too small for bank count");
  end

  logic [NUM_BANKS*SRC_W-1:0] status_flat;
  logic [NUM_BANKS*SRC_W-1:0] enable_flat;
  logic [NUM_BANKS*SRC_W-1:0] edge_flat;
  logic [NUM_BANKS-1:0][SRC_W-1:0] bank_rd;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * BANK_STRIDE;
    logic [ADDR_W:0]    rel;
    logic               hit;
    logic [OFS_W-1:0]   off;
    bank_wr_t           wr;
    logic [SRC_W-1:0]   rd_raw;

    always_comb begin
      rel         = {1'b0, bus_addr} - (ADDR_W+1)'(BASE);
      hit         = !rel[ADDR_W] && (rel < (ADDR_W+1)'(BANK_STRIDE));
      off         = rel[OFS_W-1:0];
      wr.enable   = bus_we && hit && (off == OFS_ENABLE);
      wr.set      = bus_we && hit && (off == OFS_SET);
      wr.clear    = bus_we && hit && (off == OFS_CLEAR);
      wr.pol      = bus_we && hit && (off == OFS_POL);
      wr.edge_sel = bus_we && hit && (off == OFS_EDGE);
      bank_rd[b]  = hit ? rd_raw : '0;
    end

    intc_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[b*SRC_W +: SRC_W]),
      .wr_i      (wr),
      .wdata_i   (bus_wdata),
      .rd_off_i  (off),
      .rd_data_o (rd_raw),
      .status_o  (status_flat[b*SRC_W +: SRC_W]),
      .enable_o  (enable_flat[b*SRC_W +: SRC_W]),
      .edge_o    (edge_flat[b*SRC_W +: SRC_W]),
      .irq_o     (irq_o[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rd[b];
  end
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [NUM_BANKS-1:0]    irq_o,
  input logic [NUM_BANKS*32-1:0] status_flat,
  input logic [NUM_BANKS*32-1:0] enable_flat,
  input logic [NUM_BANKS*32-1:0] edge_flat
);
  logic clr0_wr, edge0_wr;
  assign clr0_wr  = bus_we && (bus_addr == ADDR_W'(12));
  assign edge0_wr = bus_we && (bus_addr == ADDR_W'(20));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    assert_no_enable_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_flat[b*32 +: 32] == '0) |-> !irq_o[b]);
  end

  assert_enable_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4)) |=> (enable_flat[31:0] == $past(bus_wdata)));

  assert_strobe_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(12)) |-> (bus_rdata == '0));

  assert_edge_latch_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr0_wr && !edge0_wr) |=>
      ((status_flat[31:0] & $past(status_flat[31:0] & edge_flat[31:0]))
        == $past(status_flat[31:0] & edge_flat[31:0])));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |-> (irq_o == '0 && status_flat == '0 && enable_flat == '0));
endmodule

bind intc_banked intc_banked_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .status_flat (status_flat),
  .enable_flat (enable_flat),
  .edge_flat   (edge_flat)
);

// File: tb/sim_intc_banked.sv
module sim_intc_banked;
  localparam int NB = 3;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NB*32-1:0] src;
  logic           bus_we;
  logic [AW-1:0]  bus_addr;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic [NB-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intc_banked #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  // {polarity, edge, first input, second input, expected status bit}
  localparam logic [4:0] VECS [0:7] = '{
    5'b10011, 5'b10100, 5'b00101, 5'b00010,
    5'b11011, 5'b11100, 5'b01101, 5'b01010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    bus_addr = 8'h00; #1; chk("R8 status", bus_rdata, 32'h0);
    bus_addr = 8'h04; #1; chk("R8 enable", bus_rdata, 32'h0);
    chk("R8 irq", {29'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R4/R3: trigger encodings on source 0
    wr(8'h04, 32'h1);
    foreach (VECS[i]) begin
      logic [4:0] v;
      v = VECS[i];
      wr(8'h10, {31'b0, v[4]});
      wr(8'h14, {31'b0, v[3]});
      src[0] = v[2];
      repeat (5) @(negedge clk);
      wr(8'h0C, 32'hFFFF_FFFF);
      src[0] = v[1];
      repeat (5) @(negedge clk);
      rd(8'h00, d);
      chk(v[3] ? "R2 R3 edge status" : "R2 R4 level status", {31'b0, d[0]}, {31'b0, v[0]});
      chk("R6 irq follows status", {31'b0, irq[0]}, {31'b0, v[0]});
    end

    // R1: map, readback, strobes and unmapped read zero
    wr(8'h1C, 32'hA5A5_0F0F);
    rd(8'h1C, d); chk("R1 bank1 enable", d, 32'hA5A5_0F0F);
    rd(8'h20, d); chk("R1 set reads zero", d, 32'h0);
    rd(8'h24, d); chk("R1 clear reads zero", d, 32'h0);
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, d); chk("R1 bank2 polarity", d, 32'h1234_5678);
    rd(8'h48, d); chk("R1 unmapped", d, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h40, 32'h0);

    // R3: rising edge on source 0, zero clear bits ignored, one clears
    wr(8'h10, 32'h1); wr(8'h14, 32'h1);
    src[0] = 1'b0; repeat (5) @(negedge clk);
    wr(8'h0C, 32'hFFFF_FFFF);
    src[0] = 1'b1; repeat (5) @(negedge clk);
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h00, d); chk("R3 zero bits keep latch", {31'b0, d[0]}, 32'h1);
    wr(8'h0C, 32'h1);
    rd(8'h00, d); chk("R3 one bit clears", {31'b0, d[0]}, 32'h0);

    // R6: pending but not enabled keeps irq low
    src[0] = 1'b0; repeat (5) @(negedge clk);
    src[0] = 1'b1; repeat (5) @(negedge clk);
    wr(8'h04, 32'h0);
    chk("R6 disabled no irq", {31'b0, irq[0]}, 32'h0);

    // R4: active level survives a clear write
    wr(8'h14, 32'h0);
    repeat (3) @(negedge clk);
    wr(8'h0C, 32'h1);
    @(negedge clk);
    rd(8'h00, d); chk("R4 level survives clear", {31'b0, d[0]}, 32'h1);

    // R5: software set on edge-mode bit 5 of bank 2 is sticky
    wr(8'h44, 32'h20);
    wr(8'h38, 32'h20);
    repeat (3) @(negedge clk);
    rd(8'h30, d); chk("R5 set sticky", d, 32'h20);
    wr(8'h3C, 32'h20);

    // R7: synchronizer latency on source 0, rising edge
    wr(8'h14, 32'h1);
    src[0] = 1'b0; repeat (5) @(negedge clk);
    wr(8'h0C, 32'hFFFF_FFFF);
    bus_addr = 8'h00;
    src[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1; chk("R7 not yet after two edges", {31'b0, bus_rdata[0]}, 32'h0);
    @(negedge clk); #1; chk("R7 visible on third edge", {31'b0, bus_rdata[0]}, 32'h1);

    // R9: global source 40 -> bank 1, bit 8
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    wr(8'h28, 32'h100); wr(8'h2C, 32'h100); wr(8'h1C, 32'h100);
    src[40] = 1'b0; repeat (5) @(negedge clk);
    wr(8'h24, 32'hFFFF_FFFF);
    src[40] = 1'b1; repeat (5) @(negedge clk);
    rd(8'h18, d); chk("R9 bank1 bit8", d, 32'h100);
    chk("R9 only bank1 irq", {29'b0, irq}, 32'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule